// File: doc/BRIEF.md
# OTP Calibration Command Controller

This block sits behind a byte-wide host interface and takes care of the commands that touch a one-time-programmable calibration store. Each incoming byte carries a flag that marks it as a command or as data. The block decodes three opcodes. The first sets up calibration mode, programming permission and a three-bit row address from the data byte that follows it. The second wakes the device from sleep, and as a side effect it reloads the shadow register from the modelled non-volatile image. The third opens a shift-in window, and data bytes then enter the shadow register one at a time.

The shadow register holds `DEPTH` cells of seven bits each. A shifted byte always enters cell 0, and every older cell moves one place up. The reload runs in the background for `REFRESH_CYCLES` clock cycles. While it runs, `refresh_busy` stays high and the interface keeps decoding every other byte.

Top module: `otp_cal_cmd_ctrl`

## Requirements
- R1: After reset, `cal_mode`, `prog_en`, `row_addr`, `shadow` and `refresh_busy` are all 0.
- R2: After the command byte 0xF0, the first data byte sets `cal_mode` from bit 4, `prog_en` from bit 3 and `row_addr` from bits 2:0. Further data bytes leave these outputs unchanged.
- R3: The command byte 0x11, received while `cal_mode` is 0, raises `refresh_busy` in the next cycle. `refresh_busy` then stays high for exactly `REFRESH_CYCLES` cycles. When it falls, `shadow` equals `nv_image`.
- R4: The command byte 0x11, received while `cal_mode` is 1, does not start a refresh, and `shadow` stays unchanged.
- R5: A 0x11 command that arrives during a running refresh restarts the full `REFRESH_CYCLES` count.
- R6: While a refresh runs, other commands and data bytes are decoded as usual. For example, a 0xF0 setup applied during a refresh takes effect at once.
- R7: The command byte 0xF1, received while `cal_mode` is 1, starts shift-in. Each data byte is written to cell 0, which is `shadow[6:0]`. Cell k moves to cell k+1, which is `shadow[7k+13:7k+7]`. The top cell is discarded.
- R8: Bit 7 of a shifted data byte is dropped. Only bits 6:0 are stored.
- R9: Any command byte ends shift-in, so data bytes that follow it leave `shadow` unchanged. A 0xF1 command received while `cal_mode` is 0 does not open shift-in.
- R10: A shift-in byte can arrive on the same cycle as the last cycle of a refresh. In that case `shadow` becomes `nv_image` shifted by one cell, with the new byte in cell 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_valid | input | 1 | A byte is presented this cycle |
| byte_dc | input | 1 | 0 = command byte, 1 = data byte |
| byte_data | input | 8 | Byte value |
| nv_image | input | DEPTH*7 | Modelled non-volatile contents, cell k at bits 7k+6:7k |
| shadow | output | DEPTH*7 | Shadow register, cell k at bits 7k+6:7k |
| cal_mode | output | 1 | Calibration mode flag |
| prog_en | output | 1 | Programming enable flag |
| row_addr | output | 3 | OTP row address |
| refresh_busy | output | 1 | Reload from the non-volatile image in progress |

## Verification
The reload's terminal cycle and a shift-in data byte can fall on the same clock edge, and both then write the shadow register. To provoke this, the bench starts a refresh while calibration mode is off. It then enables calibration mode and opens shift-in while the refresh is still counting. Finally it times a data byte to land exactly on the edge where the count expires. The bench passes this case only if the loaded image appears one cell higher, with the new byte's seven low bits in cell 0, and `refresh_busy` is low at the same time.

// File: rtl/otp_cal_pkg.sv
package otp_cal_pkg;
  localparam int unsigned CELL_W  = 7;
  localparam int unsigned ROW_W   = 3;
  localparam int unsigned CAL_BIT = 4;
  localparam int unsigned PRG_BIT = 3;

  localparam logic [7:0] OP_CAL_SETUP = 8'hF0;
  localparam logic [7:0] OP_WAKE      = 8'h11;
  localparam logic [7:0] OP_SHIFT_IN  = 8'hF1;

  typedef struct packed {
    logic             cal_mode;
    logic             prog_en;
    logic [ROW_W-1:0] row;
  } otp_cfg_t;
endpackage

// File: rtl/otp_cmd_decode.sv
module otp_cmd_decode
  import otp_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_valid,
  input  logic       byte_dc,
  input  logic [7:0] byte_data,
  output otp_cfg_t   cfg,
  output logic       arg_pend,
  output logic       shift_active,
  output logic       shift_fire,
  output logic       wake_start
);
  otp_cfg_t cfg_q, cfg_d;
  logic     arg_q, arg_d;
  logic     sh_q, sh_d;
  logic     is_cmd, is_dat;

  assign is_cmd = byte_valid & ~byte_dc;
  assign is_dat = byte_valid &  byte_dc;

  always_comb begin
    cfg_d = cfg_q;
    arg_d = arg_q;
    sh_d  = sh_q;
    if (is_cmd) begin
      arg_d = (byte_data == OP_CAL_SETUP);
      sh_d  = (byte_data == OP_SHIFT_IN) && cfg_q.cal_mode;
    end else if (is_dat && arg_q) begin
      cfg_d.cal_mode = byte_data[CAL_BIT];
      cfg_d.prog_en  = byte_data[PRG_BIT];
      cfg_d.row      = byte_data[ROW_W-1:0];
      arg_d          = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      arg_q <= 1'b0;
      sh_q  <= 1'b0;
    end else if (byte_valid) begin
      cfg_q <= cfg_d;
      arg_q <= arg_d;
      sh_q  <= sh_d;
    end
  end

  assign cfg          = cfg_q;
  assign arg_pend     = arg_q;
  assign shift_active = sh_q;
  assign shift_fire   = is_dat & sh_q;
  assign wake_start   = is_cmd && (byte_data == OP_WAKE) && !cfg_q.cal_mode;
endmodule

// File: rtl/otp_refresh_timer.sv
module otp_refresh_timer #(
  parameter int unsigned CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int unsigned CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CYCLES);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    if (start)              cnt_d = CNT_LOAD;
    else if (cnt_q != '0)   cnt_d = cnt_q - CNT_ONE;
  end

  assign cnt_en = start | (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CNT_ONE) && !start;
endmodule

// File: rtl/otp_shadow_reg.sv
module otp_shadow_reg
  import otp_cal_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [DEPTH*CELL_W-1:0] nv_image,
  input  logic                    shift,
  input  logic [CELL_W-1:0]       shift_in,
  output logic [DEPTH*CELL_W-1:0] shadow
);
  localparam int unsigned W = DEPTH * CELL_W;

  logic [W-1:0] sh_q, base, sh_d;
  logic         sh_en;

  for (genvar k = 0; k < DEPTH; k++) begin : g_cell
    assign base[k*CELL_W +: CELL_W] = load ? nv_image[k*CELL_W +: CELL_W]
                                           : sh_q[k*CELL_W +: CELL_W];
    if (k == 0) begin : g_bottom
      assign sh_d[CELL_W-1:0] = shift ? shift_in : base[CELL_W-1:0];
    end else begin : g_upper
      assign sh_d[k*CELL_W +: CELL_W] = shift ? base[(k-1)*CELL_W +: CELL_W]
                                              : base[k*CELL_W +: CELL_W];
    end
  end

  assign sh_en = load | shift;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (sh_en) sh_q <= sh_d;
  end

  assign shadow = sh_q;
endmodule

// File: rtl/otp_cal_cmd_ctrl.sv
module otp_cal_cmd_ctrl
  import otp_cal_pkg::*;
#(
  parameter int unsigned DEPTH          = 8,
  parameter int unsigned REFRESH_CYCLES = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    byte_valid,
  input  logic                    byte_dc,
  input  logic [7:0]              byte_data,
  input  logic [DEPTH*CELL_W-1:0] nv_image,
  output logic [DEPTH*CELL_W-1:0] shadow,
  output logic                    cal_mode,
  output logic                    prog_en,
  output logic [ROW_W-1:0]        row_addr,
  output logic                    refresh_busy
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  otp_cfg_t   cfg;
  logic       arg_pend, shift_active, shift_fire, wake_start, refresh_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  otp_cmd_decode u_dec (
    .clk(clk), .rst_n(rst_sync_n),
    .byte_valid(byte_valid), .byte_dc(byte_dc), .byte_data(byte_data),
    .cfg(cfg), .arg_pend(arg_pend), .shift_active(shift_active),
    .shift_fire(shift_fire), .wake_start(wake_start)
  );

  otp_refresh_timer #(.CYCLES(REFRESH_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_sync_n), .start(wake_start),
    .busy(refresh_busy), .done(refresh_done)
  );

  otp_shadow_reg #(.DEPTH(DEPTH)) u_shd (
    .clk(clk), .rst_n(rst_sync_n),
    .load(refresh_done), .nv_image(nv_image),
    .shift(shift_fire), .shift_in(byte_data[CELL_W-1:0]),
    .shadow(shadow)
  );

  assign cal_mode = cfg.cal_mode;
  assign prog_en  = cfg.prog_en;
  assign row_addr = cfg.row;
endmodule

// File: rtl/otp_cal_cmd_ctrl_chk.sv
module otp_cal_cmd_ctrl_chk #(
  parameter int unsigned DEPTH = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               byte_valid,
  input logic               byte_dc,
  input logic [7:0]         byte_data,
  input logic [DEPTH*7-1:0] nv_image,
  input logic [DEPTH*7-1:0] shadow,
  input logic               cal_mode,
  input logic               prog_en,
  input logic [2:0]         row_addr,
  input logic               refresh_busy,
  input logic               arg_pend,
  input logic               shift_active,
  input logic               shift_fire,
  input logic               refresh_done
);
  localparam int unsigned W = DEPTH * 7;

  p_cfg_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (arg_pend && byte_valid && byte_dc) |=>
      (cal_mode == $past(byte_data[4]) && prog_en == $past(byte_data[3]) &&
       row_addr == $past(byte_data[2:0])));

  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(arg_pend && byte_valid && byte_dc) |=>
      ($stable(cal_mode) && $stable(prog_en) && $stable(row_addr)));

  p_wake_starts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !byte_dc && byte_data == 8'h11 && !cal_mode) |=> refresh_busy);

  p_refresh_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(refresh_busy) && !$past(shift_fire)) |-> (shadow == $past(nv_image)));

  p_wake_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !byte_dc && byte_data == 8'h11 && cal_mode && !refresh_busy)
      |=> !refresh_busy);

  p_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_fire && !refresh_done) |=>
      (shadow[6:0] == $past(byte_data[6:0]) && shadow[W-1:7] == $past(shadow[W-8:0])));

  p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_fire && !refresh_done) |=> $stable(shadow));

  p_shift_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !byte_dc && byte_data != 8'hF1) |=> !shift_active);

  p_collide_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_fire && refresh_done) |=>
      (shadow == {$past(nv_image[W-8:0]), $past(byte_data[6:0])}));
endmodule

bind otp_cal_cmd_ctrl otp_cal_cmd_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_sync_n),
  .byte_valid(byte_valid), .byte_dc(byte_dc), .byte_data(byte_data),
  .nv_image(nv_image), .shadow(shadow), .cal_mode(cal_mode),
  .prog_en(prog_en), .row_addr(row_addr), .refresh_busy(refresh_busy),
  .arg_pend(arg_pend), .shift_active(shift_active),
  .shift_fire(shift_fire), .refresh_done(refresh_done)
);

// File: tb/otp_cal_cmd_ctrl_bench.sv
module otp_cal_cmd_ctrl_bench;
  localparam int unsigned DEPTH = 8;
  localparam int unsigned NREF  = 16;
  localparam int unsigned W     = DEPTH * 7;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         byte_valid = 1'b0;
  logic         byte_dc = 1'b0;
  logic [7:0]   byte_data = 8'h00;
  logic [W-1:0] nv_image = '0;
  logic [W-1:0] shadow;
  logic         cal_mode, prog_en, refresh_busy;
  logic [2:0]   row_addr;

  int unsigned  checks = 0;
  int unsigned  failures = 0;
  bit           finished = 1'b0;
  logic [W-1:0] exp_sh = '0;

  always #4 clk = ~clk;

  otp_cal_cmd_ctrl #(.DEPTH(DEPTH), .REFRESH_CYCLES(NREF)) u_otp_cal_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_dc(byte_dc),
    .byte_data(byte_data), .nv_image(nv_image), .shadow(shadow),
    .cal_mode(cal_mode), .prog_en(prog_en), .row_addr(row_addr),
    .refresh_busy(refresh_busy)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic dc, input logic [7:0] d);
    byte_valid = 1'b1; byte_dc = dc; byte_data = d;
    @(negedge clk);
  endtask

  task automatic send(input logic dc, input logic [7:0] d);
    drive(dc, d);
    byte_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    byte_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (refresh_busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic shift_model(input logic [7:0] d);
    exp_sh = {exp_sh[W-8:0], d[6:0]};
  endtask

  task automatic t_reset;
    check("R1 cal_mode", 64'(cal_mode), 0);
    check("R1 prog_en", 64'(prog_en), 0);
    check("R1 row_addr", 64'(row_addr), 0);
    check("R1 shadow", 64'(shadow), 0);
    check("R1 busy", 64'(refresh_busy), 0);
  endtask

  task automatic t_config;
    send(0, 8'hF0); send(1, 8'h1D);
    check("R2 setup fields", {61'(cal_mode), prog_en, row_addr} , {61'd1, 1'b1, 3'd5});
    send(1, 8'h02);
    check("R2 extra data ignored", {61'(cal_mode), prog_en, row_addr}, {61'd1, 1'b1, 3'd5});
    send(0, 8'hF0); send(1, 8'hE6);
    check("R2 bits 7:5 dont care", {61'(cal_mode), prog_en, row_addr}, {61'd0, 1'b0, 3'd6});
  endtask

  task automatic t_refresh;
    int n;
    nv_image = 56'h0123_4567_89AB_CD;
    send(0, 8'h11);
    busy_len(n);
    check("R3 busy length", 64'(n), 64'(NREF));
    check("R3 shadow loaded", 64'(shadow), 64'(nv_image));
    exp_sh = nv_image;
  endtask

  task automatic t_blocked;
    int n;
    send(0, 8'hF0); send(1, 8'h10);
    nv_image = 56'hFF_EEDD_CCBB_AA99;
    send(0, 8'h11);
    check("R4 no busy", 64'(refresh_busy), 0);
    idle(NREF + 2);
    check("R4 shadow kept", 64'(shadow), 64'(exp_sh));
    busy_len(n);
    check("R4 never busy", 64'(n), 0);
  endtask

  task automatic t_shift;
    send(0, 8'hF1);
    send(1, 8'h81); shift_model(8'h81);
    send(1, 8'h7F); shift_model(8'h7F);
    send(1, 8'h22); shift_model(8'h22);
    check("R7 shift three bytes", 64'(shadow), 64'(exp_sh));
    check("R8 bit7 dropped cell2", 64'(shadow[20:14]), 64'h01);
  endtask

  task automatic t_shift_end;
    send(0, 8'h00);
    send(1, 8'h55);
    check("R9 data after command", 64'(shadow), 64'(exp_sh));
    send(0, 8'hF0); send(1, 8'h00);
    send(0, 8'hF1); send(1, 8'h33);
    check("R9 shift needs cal_mode", 64'(shadow), 64'(exp_sh));
  endtask

  task automatic t_overflow;
    send(0, 8'hF0); send(1, 8'h10);
    send(0, 8'hF1);
    for (int i = 0; i < 9; i++) begin
      send(1, 8'(8'h40 + i)); shift_model(8'(8'h40 + i));
    end
    check("R7 top cell discarded", 64'(shadow), 64'(exp_sh));
  endtask

  task automatic t_restart;
    int n;
    send(0, 8'hF0); send(1, 8'h00);
    nv_image = 56'h11_2233_4455_6677;
    send(0, 8'h11);
    idle(5);
    check("R5 busy mid refresh", 64'(refresh_busy), 1);
    send(0, 8'h11);
    busy_len(n);
    check("R5 full count after restart", 64'(n), 64'(NREF));
    check("R5 shadow loaded", 64'(shadow), 64'(nv_image));
    exp_sh = nv_image;
  endtask

  task automatic t_busy_accepts;
    int n;
    nv_image = 56'h0A_0B0C_0D0E_0F10;
    send(0, 8'h11);
    idle(2);
    send(0, 8'hF0); send(1, 8'h0A);
    check("R6 setup during refresh", {60'(refresh_busy), prog_en, row_addr}, {60'd1, 1'b1, 3'd2});
    busy_len(n);
    check("R6 refresh still completes", 64'(shadow), 64'(nv_image));
  endtask

  task automatic t_collision;
    nv_image = 56'h5A_6B7C_0D1E_2F30;
    drive(0, 8'h11);
    drive(0, 8'hF0);
    drive(1, 8'h10);
    drive(0, 8'hF1);
    idle(NREF - 4);
    send(1, 8'hC4);
    check("R10 busy ended", 64'(refresh_busy), 0);
    check("R10 load then shift", 64'(shadow), 64'({nv_image[W-8:0], 7'h44}));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(3);
    t_reset();
    t_config();
    t_refresh();
    t_blocked();
    t_shift();
    t_shift_end();
    t_overflow();
    t_restart();
    t_busy_accepts();
    t_collision();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule